// File: doc/BRIEF.md
# Radio Transmit Buffer Loader

This block moves one outgoing IEEE 802.15.4 MAC frame into the transmit buffer of a radio transceiver. The frame arrives through a byte stream. Its length is announced first on a separate length handshake. The block drives a register-write command port that reaches two spaces in the radio. The short space holds control registers. The long space holds the transmit buffer.

For each frame, the block first enables the transmit-done interrupt in the radio. It then captures the two frame-control bytes and works out the MAC header length from their addressing-mode and PAN-compression fields. Next it writes the buffer image: header length, frame length, then every frame byte, at consecutive long addresses starting at zero. It fires the transmit trigger and then waits for the transmit-done interrupt line. Once the line is seen, it masks the interrupt again and becomes ready for the next frame.

Back-pressure works as follows. `wr_valid` and its address and data stay constant until `wr_ready` is high on a clock edge. `s_ready` is high only when the byte on `s_data` can be taken on that edge. In the body of the frame, this means `s_ready` follows `wr_ready`. `len_ready` is high only while the block is idle. There is no last-byte marker: the announced length alone sets how many stream bytes are taken.

Top module: `txl_loader`

## Requirements
- R1: After reset: `busy` is 0, `len_err` is 0, `wr_valid` is 0, `s_ready` is 0 and `len_ready` is 1.
- R2: The header length is 3, plus 4 when the destination mode (byte 1, bits 3:2) is 2 (short), plus 10 when it is 3 (extended). Modes 0 and 1 add nothing.
- R3: The source mode (byte 1, bits 7:6) adds 2 for code 2 or 8 for code 3. When that mode is 2 or 3 and the PAN-compression bit (byte 0, bit 6) is 0, a further 2 is added.
- R4: The buffer image goes to the long space (`wr_long`=1) in this order: header length at address 0, frame length at address 1, then frame byte k at address 2+k, with no byte dropped or repeated.
- R5: The first write of each frame goes to short address 0x32 with the value 0xFE (the idle mask 0xFF with bit 0, transmit-done, cleared). It comes before any buffer write.
- R6: After the last frame byte, the block writes once to short address 0x1B. Bit 0 (trigger) is 1. Bit 2 equals bit 5 (ack request) of frame byte 0. All other bits are 0.
- R7: After the trigger, the block waits for `irq_txdone`. One cycle after seeing it, the block writes 0xFF to short address 0x32 and then returns to idle. A pulse on `irq_txdone` before the trigger write has no effect.
- R8: A length below 3 or above 127 is accepted on the length handshake and rejected. `len_err` pulses for one cycle, no write is issued, no stream byte is taken, and the block stays idle.
- R9: `busy` is high from the edge that accepts a valid length until the edge that completes the re-mask write. `wr_valid` is never high while `busy` is low.
- R10: A write that is not accepted keeps `wr_valid`, `wr_long`, `wr_addr` and `wr_data` steady until `wr_ready`. Gaps in `s_valid` and in `wr_ready` do not change the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_valid | input | 1 | Frame length offered |
| len_ready | output | 1 | Length taken (block idle) |
| len_bytes | input | 8 | Frame length in bytes |
| s_valid | input | 1 | Stream byte offered |
| s_ready | output | 1 | Stream byte taken on this edge |
| s_data | input | 8 | Stream byte |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Register write accepted |
| wr_long | output | 1 | 1 = long (buffer) space, 0 = short space |
| wr_addr | output | 10 | Register address, short addresses zero-extended |
| wr_data | output | 8 | Register write value |
| irq_txdone | input | 1 | Transmit-complete interrupt |
| busy | output | 1 | A frame is in progress |
| len_err | output | 1 | One-cycle pulse: length rejected |

## Verification
A write counts as issued on the edge where `wr_valid` and `wr_ready` are both high. A monitor records every such edge, so the image check does not depend on how many cycles back-pressure and stream gaps add. Two results are fixed in time, and the bench samples each one at the falling edge exactly that many edges after its stimulus:
- `len_err` is high at the first falling edge after the edge that takes a bad length.
- With `wr_ready` held high, the re-mask write lands on the second edge after `irq_txdone` is seen, and `busy` is low at the falling edge that follows.

Header lengths are computed by hand for each addressing pattern in the vector table. The mode-1 code and both the compressed and uncompressed source PAN cases are included.

// File: rtl/txl_pkg.sv
package txl_pkg;
  localparam int BYTE_W = 8;

  // frame-control field positions
  localparam int FC0_ACK   = 5;
  localparam int FC0_INTRA = 6;
  localparam int FC1_DST_LSB = 2;
  localparam int FC1_SRC_LSB = 6;

  localparam logic [1:0] AM_SHORT = 2'd2;
  localparam logic [1:0] AM_EXT   = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNMASK,
    ST_FC0,
    ST_FC1,
    ST_HLEN,
    ST_FLEN,
    ST_B0,
    ST_B1,
    ST_BODY,
    ST_TRIG,
    ST_WAIT,
    ST_REMASK
  } txl_state_e;
endpackage

// File: rtl/txl_hdrlen.sv
module txl_hdrlen
  import txl_pkg::*;
(
  input  logic              intra,
  input  logic [1:0]        dst_mode,
  input  logic [1:0]        src_mode,
  output logic [BYTE_W-1:0] hdr_len
);
  localparam logic [BYTE_W-1:0] BASE_LEN  = 8'd3;
  localparam logic [BYTE_W-1:0] PAN_LEN   = 8'd2;
  localparam logic [BYTE_W-1:0] SHORT_LEN = 8'd2;
  localparam logic [BYTE_W-1:0] EXT_LEN   = 8'd8;

  logic [BYTE_W-1:0] dst_add;
  logic [BYTE_W-1:0] src_add;

  always_comb begin
    unique case (dst_mode)
      AM_SHORT: dst_add = PAN_LEN + SHORT_LEN;
      AM_EXT:   dst_add = PAN_LEN + EXT_LEN;
      default:  dst_add = '0;
    endcase
  end

  always_comb begin
    unique case (src_mode)
      AM_SHORT: src_add = SHORT_LEN + (intra ? 8'd0 : PAN_LEN);
      AM_EXT:   src_add = EXT_LEN + (intra ? 8'd0 : PAN_LEN);
      default:  src_add = '0;
    endcase
  end

  assign hdr_len = BASE_LEN + dst_add + src_add;
endmodule

// File: rtl/txl_seq.sv
module txl_seq
  import txl_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MIN_FRAME = 3,
  parameter int MAX_FRAME = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_valid,
  input  logic [BYTE_W-1:0] len_bytes,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              wr_ready,
  input  logic              irq_txdone,
  output txl_state_e        state,
  output logic [BYTE_W-1:0] fc0_q,
  output logic [BYTE_W-1:0] fc1_q,
  output logic [BYTE_W-1:0] flen_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              s_ready,
  output logic              len_err
);
  localparam logic [BYTE_W-1:0] MIN_L = BYTE_W'(MIN_FRAME);
  localparam logic [BYTE_W-1:0] MAX_L = BYTE_W'(MAX_FRAME);
  localparam logic [ADDR_W-1:0] BODY_START = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [BYTE_W-1:0] HDR_BYTES = 8'd2;

  txl_state_e        state_q;
  txl_state_e        state_d;
  logic [BYTE_W-1:0] remain_q;
  logic              len_ok;
  logic              body_fire;

  assign len_ok    = (len_bytes >= MIN_L) && (len_bytes <= MAX_L);
  assign body_fire = (state_q == ST_BODY) && s_valid && wr_ready;
  assign s_ready   = (state_q == ST_FC0) || (state_q == ST_FC1) ||
                     ((state_q == ST_BODY) && wr_ready);
  assign state     = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (len_valid && len_ok) state_d = ST_UNMASK;
      ST_UNMASK: if (wr_ready) state_d = ST_FC0;
      ST_FC0:    if (s_valid) state_d = ST_FC1;
      ST_FC1:    if (s_valid) state_d = ST_HLEN;
      ST_HLEN:   if (wr_ready) state_d = ST_FLEN;
      ST_FLEN:   if (wr_ready) state_d = ST_B0;
      ST_B0:     if (wr_ready) state_d = ST_B1;
      ST_B1:     if (wr_ready) state_d = ST_BODY;
      ST_BODY:   if (body_fire && remain_q == 8'd1) state_d = ST_TRIG;
      ST_TRIG:   if (wr_ready) state_d = ST_WAIT;
      ST_WAIT:   if (irq_txdone) state_d = ST_REMASK;
      ST_REMASK: if (wr_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fc0_q    <= '0;
      fc1_q    <= '0;
      flen_q   <= '0;
      remain_q <= '0;
      addr_q   <= '0;
      len_err  <= 1'b0;
    end else begin
      state_q <= state_d;
      len_err <= (state_q == ST_IDLE) && len_valid && !len_ok;
      if (state_q == ST_IDLE && len_valid && len_ok) flen_q <= len_bytes;
      if (state_q == ST_FC0 && s_valid) fc0_q <= s_data;
      if (state_q == ST_FC1 && s_valid) fc1_q <= s_data;
      if (state_q == ST_B1 && wr_ready) begin
        remain_q <= flen_q - HDR_BYTES;
        addr_q   <= BODY_START;
      end else if (body_fire) begin
        remain_q <= remain_q - 8'd1;
        addr_q   <= addr_q + ONE_A;
      end
    end
  end
endmodule

// File: rtl/txl_wrmux.sv
module txl_wrmux
  import txl_pkg::*;
#(
  parameter int              ADDR_W      = 10,
  parameter int              SADDR_W     = 6,
  parameter logic [SADDR_W-1:0] INTCTL_ADDR = 6'h32,
  parameter logic [SADDR_W-1:0] TXCTL_ADDR  = 6'h1B,
  parameter logic [7:0]      MASK_IDLE   = 8'hFF,
  parameter int              TXDONE_BIT  = 0,
  parameter int              TRIG_BIT    = 0,
  parameter int              ACK_BIT     = 2
) (
  input  txl_state_e        state,
  input  logic [BYTE_W-1:0] fc0_q,
  input  logic [BYTE_W-1:0] fc1_q,
  input  logic [BYTE_W-1:0] flen_q,
  input  logic [BYTE_W-1:0] hdr_len,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  output logic              wr_valid,
  output logic              wr_long,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] A_INTCTL = {{(ADDR_W-SADDR_W){1'b0}}, INTCTL_ADDR};
  localparam logic [ADDR_W-1:0] A_TXCTL  = {{(ADDR_W-SADDR_W){1'b0}}, TXCTL_ADDR};
  localparam logic [BYTE_W-1:0] UNMASK_VAL = MASK_IDLE & ~(8'd1 << TXDONE_BIT);
  localparam logic [BYTE_W-1:0] TRIG_VAL   = 8'd1 << TRIG_BIT;

  logic [BYTE_W-1:0] trig_data;
  assign trig_data = TRIG_VAL | ({7'd0, fc0_q[FC0_ACK]} << ACK_BIT);

  always_comb begin
    wr_valid = 1'b1;
    wr_long  = 1'b1;
    wr_addr  = '0;
    wr_data  = '0;
    unique case (state)
      ST_UNMASK: begin wr_long = 1'b0; wr_addr = A_INTCTL; wr_data = UNMASK_VAL; end
      ST_REMASK: begin wr_long = 1'b0; wr_addr = A_INTCTL; wr_data = MASK_IDLE; end
      ST_TRIG:   begin wr_long = 1'b0; wr_addr = A_TXCTL;  wr_data = trig_data; end
      ST_HLEN:   begin wr_addr = ADDR_W'(0); wr_data = hdr_len; end
      ST_FLEN:   begin wr_addr = ADDR_W'(1); wr_data = flen_q; end
      ST_B0:     begin wr_addr = ADDR_W'(2); wr_data = fc0_q; end
      ST_B1:     begin wr_addr = ADDR_W'(3); wr_data = fc1_q; end
      ST_BODY:   begin wr_valid = s_valid; wr_addr = addr_q; wr_data = s_data; end
      default:   begin wr_valid = 1'b0; wr_long = 1'b0; end
    endcase
  end
endmodule

// File: rtl/txl_loader.sv
module txl_loader
  import txl_pkg::*;
#(
  parameter int              ADDR_W      = 10,
  parameter int              SADDR_W     = 6,
  parameter int              MIN_FRAME   = 3,
  parameter int              MAX_FRAME   = 127,
  parameter logic [SADDR_W-1:0] INTCTL_ADDR = 6'h32,
  parameter logic [SADDR_W-1:0] TXCTL_ADDR  = 6'h1B,
  parameter logic [7:0]      MASK_IDLE   = 8'hFF,
  parameter int              TXDONE_BIT  = 0,
  parameter int              TRIG_BIT    = 0,
  parameter int              ACK_BIT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_valid,
  output logic              len_ready,
  input  logic [7:0]        len_bytes,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_long,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              irq_txdone,
  output logic              busy,
  output logic              len_err
);
  txl_state_e        state;
  logic [BYTE_W-1:0] fc0_q;
  logic [BYTE_W-1:0] fc1_q;
  logic [BYTE_W-1:0] flen_q;
  logic [BYTE_W-1:0] hdr_len;
  logic [ADDR_W-1:0] addr_q;

  txl_seq #(
    .ADDR_W(ADDR_W), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .len_valid(len_valid), .len_bytes(len_bytes),
    .s_valid(s_valid), .s_data(s_data), .wr_ready(wr_ready),
    .irq_txdone(irq_txdone), .state(state), .fc0_q(fc0_q), .fc1_q(fc1_q),
    .flen_q(flen_q), .addr_q(addr_q), .s_ready(s_ready), .len_err(len_err)
  );

  txl_hdrlen u_hdr (
    .intra(fc0_q[FC0_INTRA]),
    .dst_mode(fc1_q[FC1_DST_LSB +: 2]),
    .src_mode(fc1_q[FC1_SRC_LSB +: 2]),
    .hdr_len(hdr_len)
  );

  txl_wrmux #(
    .ADDR_W(ADDR_W), .SADDR_W(SADDR_W), .INTCTL_ADDR(INTCTL_ADDR),
    .TXCTL_ADDR(TXCTL_ADDR), .MASK_IDLE(MASK_IDLE), .TXDONE_BIT(TXDONE_BIT),
    .TRIG_BIT(TRIG_BIT), .ACK_BIT(ACK_BIT)
  ) u_mux (
    .state(state), .fc0_q(fc0_q), .fc1_q(fc1_q), .flen_q(flen_q),
    .hdr_len(hdr_len), .addr_q(addr_q), .s_valid(s_valid), .s_data(s_data),
    .wr_valid(wr_valid), .wr_long(wr_long), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign len_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/txl_loader_chk.sv
module txl_loader_chk #(
  parameter int              ADDR_W     = 10,
  parameter int              SADDR_W    = 6,
  parameter logic [SADDR_W-1:0] TXCTL_ADDR = 6'h1B,
  parameter int              TRIG_BIT   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              len_ready,
  input logic              s_valid,
  input logic              s_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_long,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              len_err
);
  localparam logic [ADDR_W-1:0] A_TXCTL = {{(ADDR_W-SADDR_W){1'b0}}, TXCTL_ADDR};

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_long)); // R10
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R9
  AST_NO_LEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !len_ready); // R9
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !busy); // R8
  AST_STREAM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |-> busy); // R10
  AST_TRIG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_long && wr_addr == A_TXCTL |-> wr_data[TRIG_BIT]); // R6
endmodule

bind txl_loader txl_loader_chk #(
  .ADDR_W(ADDR_W), .SADDR_W(SADDR_W), .TXCTL_ADDR(TXCTL_ADDR), .TRIG_BIT(TRIG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .len_ready(len_ready), .s_valid(s_valid),
  .s_ready(s_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_long(wr_long), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .len_err(len_err)
);

// File: tb/txl_loader_tb.sv
module txl_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [9:0] A_INT = 10'h032;
  localparam logic [9:0] A_TXC = 10'h01B;

  // {fc0, fc1, frame length, expected header length}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h01, 8'h00, 8'd5,   8'd3},   // no addressing
    {8'h61, 8'h88, 8'd12,  8'd9},   // short/short, compressed, ack
    {8'h21, 8'h88, 8'd14,  8'd11},  // short/short, not compressed, ack
    {8'h41, 8'hCC, 8'd25,  8'd21},  // ext/ext, compressed
    {8'h01, 8'hCC, 8'd30,  8'd23},  // ext/ext, not compressed
    {8'h41, 8'h08, 8'd3,   8'd7},   // dst short only, minimum length
    {8'h21, 8'hC0, 8'd127, 8'd13},  // src ext only, maximum length, ack
    {8'h01, 8'h44, 8'd8,   8'd3}    // reserved mode code 1 on both
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       len_valid = 1'b0;
  logic       len_ready;
  logic [7:0] len_bytes = '0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       wr_valid;
  logic       wr_ready = 1'b1;
  logic       wr_long;
  logic [9:0] wr_addr;
  logic [7:0] wr_data;
  logic       irq_txdone = 1'b0;
  logic       busy;
  logic       len_err;

  int errors = 0;
  int checks = 0;
  logic bp_en = 1'b0;
  int cyc = 0;

  logic       lg_long [0:1023];
  logic [9:0] lg_addr [0:1023];
  logic [7:0] lg_data [0:1023];
  int lg_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txl_loader u_dut (
    .clk(clk), .rst_n(rst_n), .len_valid(len_valid), .len_ready(len_ready),
    .len_bytes(len_bytes), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_long(wr_long),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_txdone(irq_txdone),
    .busy(busy), .len_err(len_err)
  );

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready && lg_n < 1024) begin
      lg_long[lg_n] <= wr_long;
      lg_addr[lg_n] <= wr_addr;
      lg_data[lg_n] <= wr_data;
      lg_n <= lg_n + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    wr_ready <= bp_en ? ((cyc % 3) != 1) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic push_len(input logic [7:0] v);
    len_valid = 1'b1;
    len_bytes = v;
    #1;
    while (!len_ready) tick();
    tick();
    len_valid = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    s_valid = 1'b1;
    s_data = b;
    #1;
    while (!s_ready) tick();
    tick();
    s_valid = 1'b0;
  endtask

  function automatic logic [7:0] fbyte(input int k, input logic [7:0] f0,
                                       input logic [7:0] f1, input int seed);
    if (k == 0) return f0;
    if (k == 1) return f1;
    return 8'(k * 37 + seed * 11 + 5);
  endfunction

  task automatic wait_writes(input int target);
    for (int g = 0; g < 4000 && lg_n < target; g++) tick();
  endtask

  // send a frame, optionally pulse irq mid-stream, check image and trigger
  task automatic run_frame(input logic [7:0] f0, input logic [7:0] f1,
                           input int len, input logic [7:0] hexp,
                           input int seed, input bit early_irq);
    int base;
    bit ok;
    logic [7:0] texp;
    base = lg_n;
    bp_en = 1'b1;
    push_len(8'(len));
    for (int k = 0; k < len; k++) begin
      push_byte(fbyte(k, f0, f1, seed));
      if (early_irq && k == 2) begin
        irq_txdone = 1'b1; tick(); irq_txdone = 1'b0;
      end
      if ((k % 4) == 3) tick();
    end
    wait_writes(base + len + 4);
    bp_en = 1'b0;
    tick();
    check(lg_n == base + len + 4, "R4", "write count", lg_n - base, len + 4);
    check(!lg_long[base] && lg_addr[base] == A_INT && lg_data[base] == 8'hFE,
          "R5", "unmask write", int'(lg_data[base]), 8'hFE);
    check(lg_long[base+1] && lg_addr[base+1] == 10'd0 && lg_data[base+1] == hexp,
          "R2 R3", "header length", int'(lg_data[base+1]), int'(hexp));
    ok = lg_long[base+2] && lg_addr[base+2] == 10'd1 && lg_data[base+2] == 8'(len);
    for (int k = 0; k < len; k++)
      if (!(lg_long[base+3+k] && lg_addr[base+3+k] == 10'(2+k) &&
            lg_data[base+3+k] == fbyte(k, f0, f1, seed))) ok = 1'b0;
    check(ok, "R4", "image bytes (R10 gaps)", 0, 1);
    texp = 8'h01 | (f0[5] ? 8'h04 : 8'h00);
    check(!lg_long[base+len+3] && lg_addr[base+len+3] == A_TXC &&
          lg_data[base+len+3] == texp, "R6", "trigger", int'(lg_data[base+len+3]), int'(texp));
    check(busy == 1'b1 && !len_ready, "R9", "busy while waiting", int'(busy), 1);
    if (early_irq) check(busy == 1'b1, "R7", "early irq ignored", int'(busy), 1);
    // irq seen at next edge, re-mask on the edge after, idle at the falling edge after that
    irq_txdone = 1'b1; tick(); irq_txdone = 1'b0; tick();
    check(busy == 1'b0 && len_ready, "R9", "busy drop after remask", int'(busy), 0);
    check(lg_n == base + len + 5 && !lg_long[base+len+4] && lg_addr[base+len+4] == A_INT &&
          lg_data[base+len+4] == 8'hFF, "R7", "remask write", int'(lg_data[base+len+4]), 8'hFF);
  endtask

  task automatic reject(input logic [7:0] v);
    int base;
    base = lg_n;
    push_len(v);
    check(len_err == 1'b1, "R8", "len_err pulse", int'(len_err), 1);
    tick();
    check(len_err == 1'b0, "R8", "len_err one cycle", int'(len_err), 0);
    repeat (3) tick();
    check(lg_n == base && !busy && len_ready && !s_ready, "R8", "nothing written",
          lg_n - base, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(!busy && !len_err && !wr_valid && !s_ready && len_ready, "R1", "reset state",
          {busy, len_err, wr_valid, s_ready, len_ready}, 5'b00001);

    for (int i = 0; i < NVEC; i++)
      run_frame(VEC[i][31:24], VEC[i][23:16], int'(VEC[i][15:8]), VEC[i][7:0], i, 1'b0);

    reject(8'd128);
    reject(8'd2);
    reject(8'd255);
    run_frame(8'h61, 8'h88, 6, 8'd9, 20, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule